// File: doc/BRIEF.md
# Logic probe tone selector

This block sits behind the two threshold comparators of a logic probe and drives one buzzer line. One comparator bit says the probed voltage lies above the low threshold. The other says it lies above the high threshold. From these two bits the block picks one of three sounds, so the user can hear whether the probed node is low, high, or in the undefined band between the thresholds.

Two square-wave generators run from the system clock. Each has its own divider, set at run time, so the low and high tones can be pitched apart. The third sound is the bitwise OR of the two tones. The two comparator bits arrive without any clock, so each passes through a synchronizer first. A small lookup table then turns the synchronized pair into a source select for a four-way selector. The selector output is registered to keep the buzzer line free of glitches.

The comparator combination "high asserted, low deasserted" cannot occur in a working front end. It is mapped to the undefined-band sound, so a broken probe sounds the same as a floating node.

Top module: `logic_tone_sel`

## Requirements
- R1: With a nonzero divider N, a tone generator starts low after reset and inverts its output on every Nth clock edge after reset release. Its output after k edges is therefore floor(k/N) mod 2, a square wave of period 2N.
- R2: A divider value of 0 holds that tone generator low for as long as the value stays 0.
- R3: Code {cmp_hi_i, cmp_lo_i} = 00 routes the low tone (set by div_lo_i) to the buzzer. The fourth selector input, a constant 0, is never selected.
- R4: Code 11 routes the high tone (set by div_hi_i) to the buzzer.
- R5: Code 01, meaning the input lies between the thresholds, routes the OR of the low and high tones to the buzzer.
- R6: Code 10, the impossible combination, routes the same OR-mixed sound as code 01.
- R7: A comparator input sampled at clock edge j controls the buzzer value that appears after edge j+2. This is two synchronizer stages plus the output register.
- R8: A synchronous reset drives buzz_o low after the next edge, clears both synchronizers and restarts both tone counters from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_lo_i | input | 1 | Asynchronous bit: probe voltage above the low threshold |
| cmp_hi_i | input | 1 | Asynchronous bit: probe voltage above the high threshold |
| div_lo_i | input | DIV_W | Half-period, in clock cycles, of the low tone (0 = silent) |
| div_hi_i | input | DIV_W | Half-period, in clock cycles, of the high tone (0 = silent) |
| buzz_o | output | 1 | Registered buzzer drive |

## Verification
The hardest case to reach is the impossible code 10. It has to be shown equal to the between-thresholds sound while both tones are running at different phases, and also in the cycles where the code has only just changed in the synchronizer. The bench drives that code on purpose. It sweeps every pair of small dividers, including 0, and at each pair walks the codes in an order that moves into and out of 10 from every neighbour. It predicts each buzzer cycle from the edge count since reset and the code sampled two edges earlier.

// File: rtl/logic_tone_pkg.sv
package logic_tone_pkg;

  // Source index for the buzzer selector
  typedef enum logic [1:0] {
    SRC_LOW  = 2'd0,
    SRC_MIX  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_IDLE = 2'd3
  } src_e;

  localparam int NUM_SRC   = 4;
  localparam int NUM_TONES = 2;
  localparam int TONE_LO   = 0;
  localparam int TONE_HI   = 1;

endpackage

// File: rtl/ltp_sync.sv
module ltp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      // Two clean edges after reset: output is the input from two edges back
      assert_sync_delay_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2)) |-> (dout == $past(din, 2)));
    end
  endgenerate

endmodule

// File: rtl/ltp_tone.sv
module ltp_tone #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tone
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic             tone_q;

  always_ff @(posedge clk) begin
    if (rst || (div == '0)) begin
      cnt    <= '0;
      tone_q <= 1'b0;
    end else if (cnt >= div - ONE) begin
      cnt    <= '0;
      tone_q <= ~tone_q;
    end else begin
      cnt    <= cnt + ONE;
    end
  end

  assign tone = tone_q;

  // Zero divider keeps the tone silent
  assert_zero_div_low_R2: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !tone);

  // Mid-count the output does not move
  assert_hold_midcount_R1: assert property (@(posedge clk) disable iff (rst)
    ((div != '0) && (cnt < div - ONE)) |=> $stable(tone));

  // After reset the tone restarts low
  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (!tone && (cnt == '0)));

endmodule

// File: rtl/ltp_classify.sv
module ltp_classify
  import logic_tone_pkg::*;
(
  input  logic above_lo,
  input  logic above_hi,
  output src_e src
);

  always_comb begin
    unique case ({above_hi, above_lo})
      2'b00:   src = SRC_LOW;
      2'b11:   src = SRC_HIGH;
      2'b01:   src = SRC_MIX;
      default: src = SRC_MIX;   // impossible state sounds undefined
    endcase
  end

endmodule

// File: rtl/logic_tone_sel.sv
module logic_tone_sel
  import logic_tone_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_lo_i,
  input  logic             cmp_hi_i,
  input  logic [DIV_W-1:0] div_lo_i,
  input  logic [DIV_W-1:0] div_hi_i,
  output logic             buzz_o
);

  logic [1:0]                       cmp_s;
  logic [NUM_TONES-1:0][DIV_W-1:0]  divs;
  logic [NUM_TONES-1:0]             tones;
  logic [NUM_SRC-1:0]               srcs;
  src_e                             sel;
  logic                             buzz_q;

  ltp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({cmp_hi_i, cmp_lo_i}),
    .dout (cmp_s)
  );

  assign divs[TONE_LO] = div_lo_i;
  assign divs[TONE_HI] = div_hi_i;

  generate
    for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
      ltp_tone #(.DIV_W(DIV_W)) u_tone (
        .clk  (clk),
        .rst  (rst),
        .div  (divs[t]),
        .tone (tones[t])
      );
    end
  endgenerate

  ltp_classify u_class (
    .above_lo (cmp_s[0]),
    .above_hi (cmp_s[1]),
    .src      (sel)
  );

  assign srcs[SRC_LOW]  = tones[TONE_LO];
  assign srcs[SRC_HIGH] = tones[TONE_HI];
  assign srcs[SRC_MIX]  = tones[TONE_LO] | tones[TONE_HI];
  assign srcs[SRC_IDLE] = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) buzz_q <= 1'b0;
    else     buzz_q <= srcs[sel];
  end

  assign buzz_o = buzz_q;

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> !buzz_o);

  assert_never_idle_R3: assert property (@(posedge clk) disable iff (rst)
    sel != SRC_IDLE);

  assert_low_code_R3: assert property (@(posedge clk) disable iff (rst)
    (cmp_s == 2'b00) |=> (buzz_o == $past(tones[TONE_LO])));

  assert_high_code_R4: assert property (@(posedge clk) disable iff (rst)
    (cmp_s == 2'b11) |=> (buzz_o == $past(tones[TONE_HI])));

  assert_mid_code_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_s == 2'b01) |=> (buzz_o == ($past(tones[TONE_LO]) | $past(tones[TONE_HI]))));

  assert_bad_code_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_s == 2'b10) |=> (buzz_o == ($past(tones[TONE_LO]) | $past(tones[TONE_HI]))));

endmodule

// File: tb/test_logic_tone_sel.sv
module test_logic_tone_sel;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int MAX_DIV    = 4;
  localparam int HOLD       = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmp_lo = 1'b0;
  logic          cmp_hi = 1'b0;
  logic [DW-1:0] div_lo = '0;
  logic [DW-1:0] div_hi = '0;
  logic          buzz;

  int n_run  = 0;
  int n_fail = 0;

  // Bench-side history: edges since reset and codes seen at recent edges
  int         kcnt = 0;
  logic       r1 = 1'b1;
  logic [1:0] h1 = 2'b00, h2 = 2'b00, h3 = 2'b00;

  logic_tone_sel #(.DIV_W(DW), .SYNC_STAGES(2)) i_logic_tone_sel (
    .clk      (clk),
    .rst      (rst),
    .cmp_lo_i (cmp_lo),
    .cmp_hi_i (cmp_hi),
    .div_lo_i (div_lo),
    .div_hi_i (div_hi),
    .buzz_o   (buzz)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    r1 <= rst;
    if (rst) begin
      kcnt <= 0; h1 <= 2'b00; h2 <= 2'b00; h3 <= 2'b00;
    end else begin
      kcnt <= kcnt + 1; h1 <= {cmp_hi, cmp_lo}; h2 <= h1; h3 <= h2;
    end
  end

  function automatic logic tone_at(int k, int n);
    if (n == 0) return 1'b0;
    return logic'((k / n) % 2);
  endfunction

  task automatic check_cycle();
    logic  exp_v, tl, th;
    string tag;
    int    nl, nh;
    @(negedge clk);
    nl = int'(div_lo);
    nh = int'(div_hi);
    if (r1 || kcnt == 0) begin
      exp_v = 1'b0;
      tag   = "R8";
    end else begin
      tl = tone_at(kcnt - 1, nl);
      th = tone_at(kcnt - 1, nh);
      case (h3)
        2'b00: begin exp_v = tl;      tag = (nl == 0) ? "R3 R2" : "R3 R1"; end
        2'b11: begin exp_v = th;      tag = (nh == 0) ? "R4 R2" : "R4 R1"; end
        2'b01: begin exp_v = tl | th; tag = "R5"; end
        default: begin exp_v = tl | th; tag = "R6"; end
      endcase
      if (h3 != h1) tag = {tag, " R7"};
      if (kcnt <= 3) tag = {tag, " R8"};
    end
    n_run++;
    if (buzz !== exp_v) begin
      n_fail++;
      $display("FAIL %s: buzz=%b expected=%b (k=%0d dl=%0d dh=%0d code=%b)",
               tag, buzz, exp_v, kcnt, nl, nh, h3);
    end
  endtask

  task automatic hold_code(logic [1:0] c, int cycles);
    {cmp_hi, cmp_lo} = c;
    for (int i = 0; i < cycles; i++) check_cycle();
  endtask

  initial begin
    // Reset state check (R8)
    repeat (3) check_cycle();
    for (int dl = 0; dl <= MAX_DIV; dl++) begin
      for (int dh = 0; dh <= MAX_DIV; dh++) begin
        rst    = 1'b1;
        div_lo = DW'(dl);
        div_hi = DW'(dh);
        {cmp_hi, cmp_lo} = 2'b00;
        check_cycle();
        check_cycle();
        rst = 1'b0;
        // Walk codes so 10 is entered from and left to every neighbour
        hold_code(2'b00, HOLD);
        hold_code(2'b10, HOLD);
        hold_code(2'b01, HOLD);
        hold_code(2'b10, HOLD);
        hold_code(2'b11, HOLD);
        hold_code(2'b10, HOLD);
        hold_code(2'b00, HOLD);
        hold_code(2'b11, HOLD);
        hold_code(2'b01, HOLD);
        // Mid-run reset, then restart (R8)
        rst = 1'b1;
        check_cycle();
        rst = 1'b0;
        hold_code(2'b11, HOLD);
        hold_code(2'b00, 2);
        hold_code(2'b10, 1);
        hold_code(2'b11, 1);
        hold_code(2'b01, HOLD);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule